// File: doc/BRIEF.md
# Credit-Gated Burst Read Master

This block streams a contiguous region of memory from a memory-mapped read port into a ready/valid data stream. A host-programmed base address (64 bits) and a length in data-bus beats are latched on a start pulse. The block then splits the region into incrementing bursts. Each burst is as long as it can be, but it is limited by a maximum beat count, by the beats still left to fetch, and by the next 4 KB address page edge.

Before any read address is presented, the block reserves space in its internal beat buffer for every beat of that burst. The read data channel is therefore never back-pressured, and the ready signal on that channel stays high. Several bursts can be outstanding at once, all on one transaction ID. A reserved slot becomes free again each time the consumer takes a beat from the output stream.

The block raises `busy` for the duration of a transfer. It gives a single-cycle `done` pulse once the final beat of the final burst has arrived from memory.

Top module: `burst_rd_master`

## Requirements
- R1: Every read address carries burst type INCR (encoding 2'b01), a size code equal to log2 of the bus width in bytes (full width, never narrow), and transaction ID 0.
- R2: Each burst's beat count (ar_len + 1) equals the smallest of MAX_BEATS, the beats still to be requested, and the beats left before the next 4096-byte address boundary; no burst crosses such a boundary.
- R3: The first burst starts at the latched base address, each following burst starts where the previous one ended, and the bursts together cover exactly the requested number of beats.
- R4: A read address is presented only when the buffer has unreserved room for all of its beats, so the number of beats requested and not yet taken by the consumer never exceeds BUF_DEPTH.
- R5: The read data ready output is high in every cycle after reset.
- R6: Output beats appear in address order, with the data exactly as received; while out_valid is high and out_ready is low, out_data is held.
- R7: Buffer space comes back one beat at a time as the consumer drains, so a transfer longer than BUF_DEPTH completes.
- R8: busy is high from the cycle after an accepted start until the final read beat is taken; done pulses for one cycle, in the cycle after that final beat.
- R9: A start pulse while busy is high is ignored and does not change the transfer in progress.
- R10: A start with a beat count of 0 issues no read address and pulses done in the next cycle, with busy staying low.
- R11: After reset, ar_valid, out_valid, done and busy are low.
- R12: While ar_valid is high and ar_ready is low, ar_valid stays high and ar_addr and ar_len are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transfer when not busy |
| base_addr | input | ADDR_W | Byte address of the first beat, bus-width aligned |
| beat_count | input | LEN_W | Number of bus-width beats to read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final beat arrives |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Burst start address |
| ar_len | output | 8 | Beats in burst minus one |
| ar_size | output | 3 | Bytes per beat, log2 |
| ar_burst | output | 2 | Burst type (INCR) |
| ar_id | output | ID_W | Transaction ID (constant 0) |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready (held high) |
| r_data | input | DATA_W | Read data beat |
| out_valid | output | 1 | Stream beat available |
| out_ready | input | 1 | Stream consumer takes the beat |
| out_data | output | DATA_W | Stream data beat |

## Verification
Four properties are checked on every cycle:
- a presented address is held until it is accepted;
- no presented burst runs past a 4 KB page;
- a reservation never exceeds the free buffer space, and the buffer never overflows;
- a stalled output beat keeps its data, done never lasts two cycles, and no address is pending while the block is idle.

The exact burst lengths and their addresses can only be shown by the bench's scenarios. The same holds for beat ordering across bursts, the timing of the done pulse, the ignored start and the zero-length case. The bench sweeps start offsets near a page edge against many lengths, and derives every expected burst from a min of three limits.

// File: rtl/brm_pkg.sv
package brm_pkg;
   localparam int PAGE_BYTES = 4096;
   localparam int PAGE_W     = 12;
   localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/brm_burst_sizer.sv
module brm_burst_sizer #(
   parameter int LEN_W     = 32,
   parameter int BYTES     = 64,
   parameter int MAX_BEATS = 256,
   parameter int BEAT_W    = 9
) (
   input  logic [brm_pkg::PAGE_W-$clog2(BYTES)-1:0] page_beat,
   input  logic [LEN_W-1:0]                         beats_left,
   output logic [BEAT_W-1:0]                        burst_beats
);
   localparam int LSB        = $clog2(BYTES);
   localparam int PAGE_BEATS = brm_pkg::PAGE_BYTES / BYTES;
   localparam int OFF_W      = brm_pkg::PAGE_W - LSB;
   localparam int CW         = ((LEN_W > OFF_W + 1) ? LEN_W : OFF_W + 1) + 1;

   logic [CW-1:0] to_page;
   logic [CW-1:0] cap;
   logic [CW-1:0] left;

   assign to_page = CW'(PAGE_BEATS) - CW'(page_beat);
   assign left    = CW'(beats_left);

   generate
      if (MAX_BEATS >= PAGE_BEATS) begin : g_page_only
         assign cap = to_page;
      end else begin : g_len_and_page
         assign cap = (to_page < CW'(MAX_BEATS)) ? to_page : CW'(MAX_BEATS);
      end
   endgenerate

   assign burst_beats = BEAT_W'((left < cap) ? left : cap);
endmodule

// File: rtl/brm_credit_pool.sv
module brm_credit_pool #(
   parameter int DEPTH  = 512,
   parameter int BEAT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BEAT_W-1:0] need,
   output logic              grant,
   input  logic              take,
   input  logic              give
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] avail;
   logic [CW:0]   avail_nxt;

   always_comb begin
      avail_nxt = {1'b0, avail};
      if (take) avail_nxt = avail_nxt - (CW+1)'(need);
      if (give) avail_nxt = avail_nxt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) avail <= CW'(DEPTH);
      else        avail <= avail_nxt[CW-1:0];
   end

   assign grant = ({1'b0, avail} >= (CW+1)'(need));

   p_take_covered_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ({1'b0, avail} >= (CW+1)'(need)));
   p_credit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      avail <= CW'(DEPTH));
endmodule

// File: rtl/brm_beat_fifo.sv
module brm_beat_fifo #(
   parameter int W     = 512,
   parameter int DEPTH = 512
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp;
   logic [PW-1:0] rp;
   logic [CW-1:0] count;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   assign out_valid = (count != '0);
   assign out_data  = mem[rp];

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(DEPTH)));
   p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !pop) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/burst_rd_master.sv
module burst_rd_master
   import brm_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int DATA_W    = 512,
   parameter int LEN_W     = 32,
   parameter int ID_W      = 1,
   parameter int MAX_BEATS = 256,
   parameter int BUF_DEPTH = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LEN_W-1:0]  beat_count,
   output logic              busy,
   output logic              done,
   output logic              ar_valid,
   input  logic              ar_ready,
   output logic [ADDR_W-1:0] ar_addr,
   output logic [7:0]        ar_len,
   output logic [2:0]        ar_size,
   output logic [1:0]        ar_burst,
   output logic [ID_W-1:0]   ar_id,
   input  logic              r_valid,
   output logic              r_ready,
   input  logic [DATA_W-1:0] r_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [DATA_W-1:0] out_data
);
   localparam int BYTES  = DATA_W / 8;
   localparam int LSB    = $clog2(BYTES);
   localparam int BEAT_W = $clog2(MAX_BEATS + 1);

   generate
      if (DATA_W < 8 || (1 << $clog2(DATA_W)) != DATA_W || BYTES > 128) begin : g_bad_width
         $error("DATA_W must be a power of two from 8 to 1024");
      end
      if (MAX_BEATS < 1 || MAX_BEATS > 256) begin : g_bad_max
         $error("MAX_BEATS must be 1 to 256");
      end
      if (BUF_DEPTH < MAX_BEATS || (1 << $clog2(BUF_DEPTH)) != BUF_DEPTH) begin : g_bad_depth
         $error("BUF_DEPTH must be a power of two no smaller than MAX_BEATS");
      end
      if (ADDR_W <= PAGE_W || LEN_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed the page offset width");
      end
   endgenerate

   logic [ADDR_W-1:0] cur_addr;
   logic [LEN_W-1:0]  req_left;
   logic [LEN_W-1:0]  rx_left;
   logic [BEAT_W-1:0] burst_beats;
   logic [BEAT_W-1:0] len_m1;
   logic              room_ok;
   logic              issue;
   logic              out_pop;

   brm_burst_sizer #(
      .LEN_W(LEN_W), .BYTES(BYTES), .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W)
   ) u_sizer (
      .page_beat  (cur_addr[PAGE_W-1:LSB]),
      .beats_left (req_left),
      .burst_beats(burst_beats)
   );

   brm_credit_pool #(.DEPTH(BUF_DEPTH), .BEAT_W(BEAT_W)) u_credit (
      .clk  (clk),
      .rst_n(rst_n),
      .need (burst_beats),
      .grant(room_ok),
      .take (issue),
      .give (out_pop)
   );

   brm_beat_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (r_valid),
      .push_data(r_data),
      .pop      (out_pop),
      .out_valid(out_valid),
      .out_data (out_data)
   );

   assign issue   = busy && (req_left != '0) && !ar_valid && room_ok;
   assign len_m1  = burst_beats - 1'b1;
   assign out_pop = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         ar_valid <= 1'b0;
         ar_addr  <= '0;
         ar_len   <= '0;
         cur_addr <= '0;
         req_left <= '0;
         rx_left  <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy     <= (beat_count != '0);
            done     <= (beat_count == '0);
            cur_addr <= base_addr;
            req_left <= beat_count;
            rx_left  <= beat_count;
         end
         if (ar_valid && ar_ready) ar_valid <= 1'b0;
         if (issue) begin
            ar_valid <= 1'b1;
            ar_addr  <= cur_addr;
            ar_len   <= 8'(len_m1);
            cur_addr <= cur_addr + (ADDR_W'(burst_beats) << LSB);
            req_left <= req_left - LEN_W'(burst_beats);
         end
         if (busy && r_valid) begin
            rx_left <= rx_left - 1'b1;
            if (rx_left == LEN_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign ar_size  = 3'(LSB);
   assign ar_burst = BURST_INCR;
   assign ar_id    = '0;
   assign r_ready  = 1'b1;

   p_ar_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len)));
   p_page_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ar_valid |-> (int'(ar_addr[PAGE_W-1:0]) + (int'(ar_len) + 1) * BYTES <= PAGE_BYTES));
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_idle_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ar_valid);
   p_data_in_transfer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      r_valid |-> busy);
endmodule

// File: tb/burst_rd_master_bench.sv
module burst_rd_master_bench;
   localparam int AW = 64, DW = 32, LW = 16, MB = 16, BD = 32, BYTES = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [LW-1:0] beat_count = '0;
   logic          busy, done, ar_valid, r_ready, out_valid;
   logic          ar_ready = 1'b0;
   logic [AW-1:0] ar_addr;
   logic [7:0]    ar_len;
   logic [2:0]    ar_size;
   logic [1:0]    ar_burst;
   logic [0:0]    ar_id;
   logic          r_valid = 1'b0;
   logic [DW-1:0] r_data = '0;
   logic          out_ready = 1'b0;
   logic [DW-1:0] out_data;

   burst_rd_master #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .ID_W(1),
                     .MAX_BEATS(MB), .BUF_DEPTH(BD)) u_burst_rd_master (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .beat_count(beat_count), .busy(busy), .done(done),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
      .ar_size(ar_size), .ar_burst(ar_burst), .ar_id(ar_id),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic longint exp_burst(input longint addr, input longint rem);
      longint to_pg, b;
      to_pg = (4096 - (addr % 4096)) / BYTES;
      b = MB;
      if (rem < b) b = rem;
      if (to_pg < b) b = to_pg;
      return b;
   endfunction

   logic [AW-1:0] q_addr [64];
   int            q_len  [64];

   task automatic run(input logic [AW-1:0] base, input int beats, input int mode, input bit poke);
      longint e_addr, e_rem, issued, popped;
      int qh, qt, rbeat, rx, oidx, dones, cyc;
      bit done_due, last_now, hold_ar, hold_out;
      logic [AW-1:0] h_addr;
      logic [7:0] h_len;
      logic [DW-1:0] h_data, exp_d;
      e_addr = longint'(base); e_rem = beats; issued = 0; popped = 0;
      qh = 0; qt = 0; rbeat = 0; rx = 0; oidx = 0; dones = 0; cyc = 0;
      done_due = 0; hold_ar = 0; hold_out = 0; h_addr = '0; h_len = '0; h_data = '0;
      @(negedge clk);
      base_addr = base; beat_count = LW'(beats); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (beats == 0) begin
         chk(done == 1'b1, "R10 done after zero-length start", done, 1);
         chk(busy == 1'b0, "R10 busy stays low", busy, 0);
         @(negedge clk);
         chk(done == 1'b0 && ar_valid == 1'b0 && out_valid == 1'b0,
             "R10 no request, single pulse", {done, ar_valid, out_valid}, 0);
         return;
      end
      chk(busy == 1'b1, "R8 busy after start", busy, 1);
      while (oidx < beats && cyc < 4000) begin
         if (poke && cyc == 3) begin
            start = 1'b1; base_addr = 64'hDEAD_0000; beat_count = LW'(5);
         end else begin
            start = 1'b0;
         end
         if (poke && cyc == 4)
            chk(busy == 1'b1 && done == 1'b0, "R9 start while busy ignored", {busy, done}, 2'b10);
         ar_ready  = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
         out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 2) == 0) : ((cyc % 7) == 0);
         if (qh != qt && (mode == 0 || (cyc % 4) != 2)) begin
            r_valid = 1'b1;
            r_data  = q_addr[qh][31:0] + DW'(rbeat * BYTES);
         end else begin
            r_valid = 1'b0;
         end
         #1;
         chk(r_ready == 1'b1, "R5 r_ready high", r_ready, 1);
         if (hold_ar)
            chk(ar_valid && ar_addr == h_addr && ar_len == h_len, "R12 address held",
                longint'(ar_addr), longint'(h_addr));
         if (hold_out)
            chk(out_valid && out_data == h_data, "R6 stalled beat held",
                longint'(out_data), longint'(h_data));
         if (done || done_due) begin
            chk(done == done_due, "R8 done timing", done, done_due);
            if (done) dones++;
         end
         last_now = 1'b0;
         if (ar_valid && ar_ready) begin
            longint eb;
            eb = exp_burst(e_addr, e_rem);
            chk(ar_burst == 2'b01, "R1 burst type", ar_burst, 1);
            chk(ar_size == 3'd2 && ar_id == 1'b0, "R1 size/id", {ar_size, ar_id}, 3'd2 << 1);
            chk(longint'(ar_len) + 1 == eb, "R2 burst length", longint'(ar_len) + 1, eb);
            chk(longint'(ar_addr) == e_addr, "R3 burst address", longint'(ar_addr), e_addr);
            e_addr += eb * BYTES;
            e_rem  -= eb;
            q_addr[qt] = ar_addr; q_len[qt] = int'(ar_len) + 1; qt = (qt + 1) % 64;
            issued += longint'(ar_len) + 1;
         end
         hold_ar = ar_valid && !ar_ready;
         h_addr = ar_addr; h_len = ar_len;
         if (r_valid) begin
            rx++;
            if (rx == beats) last_now = 1'b1;
            rbeat++;
            if (rbeat == q_len[qh]) begin rbeat = 0; qh = (qh + 1) % 64; end
         end
         if (out_valid && out_ready) begin
            exp_d = base[31:0] + DW'(oidx * BYTES);
            chk(out_data == exp_d, "R6 stream order/data", longint'(out_data), longint'(exp_d));
            oidx++; popped++;
         end
         hold_out = out_valid && !out_ready;
         h_data = out_data;
         chk(issued - popped <= BD, "R4 outstanding within buffer", issued - popped, BD);
         done_due = last_now;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0; r_valid = 1'b0; out_ready = 1'b0; ar_ready = 1'b0;
      chk(oidx == beats, "R7 all beats delivered", oidx, beats);
      chk(e_rem == 0, "R3 bursts cover length", e_rem, 0);
      chk(dones == 1, "R8 exactly one done", dones, 1);
      chk(busy == 1'b0, "R8 busy cleared", busy, 0);
      chk(out_valid == 1'b0, "R6 buffer drained", out_valid, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(ar_valid == 0 && out_valid == 0 && done == 0 && busy == 0,
          "R11 reset state", {ar_valid, out_valid, done, busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ar_valid == 0 && busy == 0 && r_ready == 1, "R11 idle after reset",
          {ar_valid, busy, r_ready}, 1);
      run(64'h1000, 40, 0, 0);
      run(64'h0FF8, 30, 1, 0);
      run(64'h2FC0, 17, 0, 0);
      run(64'h1_0000_3FFC, 20, 1, 0);
      run(64'h8000, 100, 2, 1);
      run(64'h5000, 1, 0, 0);
      run(64'h6000, 0, 0, 0);
      for (int off = 0; off < 6; off++)
         for (int len = 1; len <= 18; len++)
            run(64'h4000 + 64'(4 * (1024 * (len % 3) + 1024 - 8 - off)), len, (off + len) % 3, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule